// File: doc/BRIEF.md
# Eight-Function Arithmetic and Logic Unit

This block takes two unsigned operands and a three-bit operation code and returns one result of the same width. Eight operations are available: two constant results (all zeros and all ones), addition, subtraction in either operand order, and the bitwise XOR, OR and AND. No carry, borrow, overflow or status flag is produced. Arithmetic wraps modulo 2^WIDTH.

By default the result is a pure function of the present inputs. If the `REG_OUT` parameter is set, one register stage is placed after the result mux. The result then appears one rising clock edge after the inputs, and the active-low asynchronous reset clears it. The operand width is a parameter and defaults to four bits.

Top module: `alu8_core`

## Requirements
- R1: Operation code 3'b000 yields a result of all zeros, whatever the operands.
- R2: Operation code 3'b001 yields b_i minus a_i modulo 2^WIDTH; the borrow is discarded.
- R3: Operation code 3'b010 yields a_i minus b_i modulo 2^WIDTH; the borrow is discarded.
- R4: Operation code 3'b011 yields a_i plus b_i modulo 2^WIDTH; the carry is discarded.
- R5: Operation code 3'b100 yields the bitwise XOR of the operands.
- R6: Operation code 3'b101 yields the bitwise OR of the operands.
- R7: Operation code 3'b110 yields the bitwise AND of the operands.
- R8: Operation code 3'b111 yields a result of all ones, whatever the operands.
- R9: With REG_OUT=0 the result follows any change on a_i, b_i or op_i without waiting for a clock edge, and holds no state.
- R10: With REG_OUT=1 the result changes only at a rising edge of clk_i and then shows the function of the inputs sampled at that edge. While rst_ni is low the result is all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock for the optional output register |
| rst_ni | input | 1 | Active-low asynchronous reset for the optional output register |
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| op_i | input | 3 | Operation code |
| res_o | output | WIDTH | Result |

## Verification
The unit holds no state in its default form, so a fault in the shared adder shows up on res_o as soon as the inputs settle. Examples are a swapped operand steer or a missing carry-in on subtraction. These faults appear only for the operand pairs that expose them, which is why every arithmetic code is swept over all operand pairs. In the registered form, a result computed from the wrong inputs appears after exactly one edge. A result that changes before the edge, or that is not cleared by reset, is visible between edges.

// File: rtl/alu8_pkg.sv
`timescale 1ns/1ps
package alu8_pkg;
  typedef enum logic [2:0] {
    OP_CLR = 3'b000,
    OP_BSA = 3'b001,
    OP_ASB = 3'b010,
    OP_ADD = 3'b011,
    OP_XOR = 3'b100,
    OP_OR  = 3'b101,
    OP_AND = 3'b110,
    OP_SET = 3'b111
  } alu_op_e;
endpackage

// File: rtl/alu8_addsub.sv
`timescale 1ns/1ps
// One adder serves add, a-b and b-a; swap steers which operand is inverted.
module alu8_addsub #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             sub_i,
  input  logic             swap_i,
  output logic [WIDTH-1:0] sum_o
);
  logic [WIDTH-1:0] lhs, rhs, rhs_x;

  always_comb begin
    lhs   = swap_i ? b_i : a_i;
    rhs   = swap_i ? a_i : b_i;
    rhs_x = sub_i ? ~rhs : rhs;
    sum_o = lhs + rhs_x + WIDTH'(sub_i);
  end
endmodule

// File: rtl/alu8_logic.sv
`timescale 1ns/1ps
module alu8_logic #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [1:0]       sel_i,
  output logic [WIDTH-1:0] res_o
);
  always_comb begin
    unique case (sel_i)
      2'b00:   res_o = a_i ^ b_i;
      2'b01:   res_o = a_i | b_i;
      2'b10:   res_o = a_i & b_i;
      default: res_o = '1;
    endcase
  end
endmodule

// File: rtl/alu8_core.sv
`timescale 1ns/1ps
module alu8_core
  import alu8_pkg::*;
#(
  parameter int WIDTH   = 4,
  parameter bit REG_OUT = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [2:0]       op_i,
  output logic [WIDTH-1:0] res_o
);
  alu_op_e          op;
  logic [WIDTH-1:0] arith_res, logic_res, res_d;
  logic             is_sub, is_swap;

  assign op      = alu_op_e'(op_i);
  assign is_sub  = (op == OP_BSA) || (op == OP_ASB);
  assign is_swap = (op == OP_BSA);

  alu8_addsub #(.WIDTH(WIDTH)) u_addsub (
    .a_i   (a_i),
    .b_i   (b_i),
    .sub_i (is_sub),
    .swap_i(is_swap),
    .sum_o (arith_res)
  );

  alu8_logic #(.WIDTH(WIDTH)) u_logic (
    .a_i  (a_i),
    .b_i  (b_i),
    .sel_i(op_i[1:0]),
    .res_o(logic_res)
  );

  always_comb begin
    unique case (op)
      OP_CLR:                 res_d = '0;
      OP_SET:                 res_d = '1;
      OP_BSA, OP_ASB, OP_ADD: res_d = arith_res;
      default:                res_d = logic_res;
    endcase
  end

  generate
    if (REG_OUT) begin : g_reg
      logic [WIDTH-1:0] res_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) res_q <= '0;
        else         res_q <= res_d;
      end
      assign res_o = res_q;
    end else begin : g_comb
      logic unused_clk_rst;
      assign unused_clk_rst = clk_i ^ rst_ni;
      assign res_o = res_d;
    end
  endgenerate
endmodule

// File: rtl/alu8_core_chk.sv
`timescale 1ns/1ps
module alu8_core_chk #(
  parameter int WIDTH   = 4,
  parameter bit REG_OUT = 1'b0
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic [2:0]       op_i,
  input logic [WIDTH-1:0] res_o
);
  generate
    if (!REG_OUT) begin : g_comb
      assert_clear_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        op_i == 3'b000 |-> res_o == '0);
      assert_rev_sub_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        op_i == 3'b001 |-> WIDTH'(res_o + a_i) == b_i);
      assert_sub_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        op_i == 3'b010 |-> WIDTH'(res_o + b_i) == a_i);
      assert_add_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        op_i == 3'b011 |-> WIDTH'(res_o - b_i) == a_i);
      assert_preset_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        op_i == 3'b111 |-> res_o == '1);
      assert_no_state_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $stable(a_i) && $stable(b_i) && $stable(op_i) |-> $stable(res_o));
    end else begin : g_reg
      assert_clear_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        op_i == 3'b000 |=> res_o == '0);
      assert_preset_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        op_i == 3'b111 |=> res_o == '1);
      assert_one_edge_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        op_i == 3'b011 |=> WIDTH'(res_o - $past(b_i)) == $past(a_i));
      assert_rev_sub_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        op_i == 3'b001 |=> WIDTH'(res_o + $past(a_i)) == $past(b_i));
    end
  endgenerate
endmodule

bind alu8_core alu8_core_chk #(.WIDTH(WIDTH), .REG_OUT(REG_OUT)) u_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .a_i   (a_i),
  .b_i   (b_i),
  .op_i  (op_i),
  .res_o (res_o)
);

// File: tb/tb_alu8_core.sv
`timescale 1ns/1ps
module tb_alu8_core;
  localparam int W = 4;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [W-1:0] a_i = '0, b_i = '0;
  logic [2:0]   op_i = 3'b111;
  logic [W-1:0] res_c, res_r;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  alu8_core #(.WIDTH(W), .REG_OUT(1'b0)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .a_i(a_i), .b_i(b_i), .op_i(op_i), .res_o(res_c));

  alu8_core #(.WIDTH(W), .REG_OUT(1'b1)) dut_q (
    .clk_i(clk_i), .rst_ni(rst_ni), .a_i(a_i), .b_i(b_i), .op_i(op_i), .res_o(res_r));

  function automatic logic [W-1:0] model(input logic [2:0] op, input logic [W-1:0] a, b);
    case (op)
      3'b000:  return '0;
      3'b001:  return W'(b - a);
      3'b010:  return W'(a - b);
      3'b011:  return W'(a + b);
      3'b100:  return a ^ b;
      3'b101:  return a | b;
      3'b110:  return a & b;
      default: return '1;
    endcase
  endfunction

  function automatic string req_of(input logic [2:0] op);
    case (op)
      3'b000:  return "R1";
      3'b001:  return "R2";
      3'b010:  return "R3";
      3'b011:  return "R4";
      3'b100:  return "R5";
      3'b101:  return "R6";
      3'b110:  return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic chk(input string req, input logic [W-1:0] act, exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h (op=%b a=%h b=%h)", req, act, exp, op_i, a_i, b_i);
    end
  endtask

  // R10: reset clears the registered result
  task automatic test_reset();
    @(negedge clk_i);
    op_i = 3'b111; a_i = 4'h5; b_i = 4'hA;
    @(negedge clk_i);
    chk("R10 reset", res_r, '0);
    chk("R8 comb during reset", res_c, 4'hF);
    rst_ni = 1'b1;
  endtask

  // R1..R8 swept over every operand pair, both variants
  task automatic test_sweep();
    for (int op = 0; op < 8; op++) begin
      for (int a = 0; a < 16; a++) begin
        for (int b = 0; b < 16; b++) begin
          @(negedge clk_i);
          op_i = 3'(op); a_i = 4'(a); b_i = 4'(b);
          #1;
          chk(req_of(op_i), res_c, model(op_i, a_i, b_i));
          @(posedge clk_i);
          #2;
          chk({req_of(op_i), " R10 reg"}, res_r, model(op_i, a_i, b_i));
        end
      end
    end
  endtask

  // R9: combinational output tracks inputs between edges
  task automatic test_comb_follow();
    @(negedge clk_i);
    op_i = 3'b011; a_i = 4'h9; b_i = 4'h9;
    #1 chk("R9 follow add", res_c, 4'h2);
    op_i = 3'b001;
    #1 chk("R9 follow op", res_c, 4'h0);
    a_i = 4'h3;
    #1 chk("R9 follow a", res_c, 4'h6);
    b_i = 4'h0;
    #1 chk("R9 follow b", res_c, 4'hD);
  endtask

  // R10: registered output holds between edges, updates at the edge
  task automatic test_reg_hold();
    @(negedge clk_i);
    op_i = 3'b011; a_i = 4'hF; b_i = 4'h1;
    @(posedge clk_i); #2;
    chk("R10 load", res_r, 4'h0);
    op_i = 3'b111;
    #1 chk("R10 hold", res_r, 4'h0);
    @(posedge clk_i); #2;
    chk("R10 update", res_r, 4'hF);
    rst_ni = 1'b0;
    #1 chk("R10 async reset", res_r, 4'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  initial begin
    test_reset();
    test_sweep();
    test_comb_follow();
    test_reg_hold();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule